// File: doc/BRIEF.md
# Keypad Lock and Unlock Sequencer

This block sits between the key and input event source and the event FIFO. While the keypad is unlocked, events flow straight through to the FIFO. Once software locks the keypad, events are consumed and dropped, so the FIFO does not fill and no key-event interrupt is raised. The only exceptions are one wake-up request and, if configured, general-purpose input events. The keypad is released only when two programmed unlock codes are pressed in order, within a time window.

When the wake timer field is nonzero, the first press after locking produces one key-event interrupt request. The host can use it to light the display and prompt the user. After that the block stays silent until the wake timer runs out or the correct sequence is entered. A successful unlock sets a sticky keylock interrupt status flag and returns the block to the unlocked state. Both timers count a slow `tick` input that pulses once per second.

Both event interfaces use valid/ready. An event is accepted on a clock edge where `ev_valid` and `ev_ready` are both high. While `ev_valid` is high and `ev_ready` is low, the source must hold `ev_data` steady. While events pass through, `ev_ready` follows `rec_ready`, so FIFO back-pressure reaches the source. While events are dropped, `ev_ready` is held high, so the source drains at full rate.

Top module: `keylock_seq`

## Requirements
- R1: During and right after reset the block is unlocked. `lck_stat` is 00, and `lock_int_stat`, `lock_irq`, `ke_int_req` and `gpi_gate` are all 0.
- R2: While unlocked, `rec_valid` equals `ev_valid`, `rec_data` equals `ev_data`, and `ev_ready` equals `rec_ready`.
- R3: While locked, an event whose code is not a general-purpose input code is never offered: `rec_valid` is 0 and `ev_ready` is 1.
- R4: When the wake field `tmr_cfg[4:0]` is nonzero, the first accepted press after locking raises `ke_int_req` for exactly one cycle, in the cycle after acceptance. It also loads the wake timer. Further presses raise no request while that timer runs.
- R5: The wake timer expires on its N-th counted tick, where N is `tmr_cfg[4:0]`. Expiry restarts the unlock sequence, and the next press raises `ke_int_req` again.
- R6: When `tmr_cfg[4:0]` is 0, `ke_int_req` is never raised.
- R7: An event matches an unlock code only if it is a press (bit 7 = 1) and equals the programmed 8-bit code, whose bit 7 must also be 1. Pressing `u1_code` and then `u2_code` unlocks the block. In the next cycle `lck_stat` is 00, `lock_int_stat` is 1, and events pass through again.
- R8: `lock_irq` is high only while `lock_int_stat` is 1 and `lk_irq_mask` is 1. A pulse on `lock_int_clr` clears `lock_int_stat`.
- R9: Matching the first code loads a window timer from `tmr_cfg[7:5]`. On its W-th counted tick the sequence falls back to waiting for the first code. A window value of 0 means there is no time limit.
- R10: Any press that matches neither code at its step restarts the sequence, and a press of `u1_code` at any point restarts the window. Release events (bit 7 = 0) leave the sequence unchanged.
- R11: General-purpose input codes run from 97 to 114 in bits 6:0. While locked, such events pass to the FIFO when `gpi_lock_cfg` is 0 and are dropped when it is 1. `gpi_gate` is high exactly while the block is locked and `gpi_lock_cfg` is 1. These codes are also valid unlock codes.
- R12: `lck_stat` bit 1 is 1 while locked. Bit 0 is 1 while locked and the first code has not yet been matched. The value 01 never occurs.
- R13: A tick in the same cycle as an accepted event is not counted by either timer.
- R14: A `lock_set` pulse while already locked has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle pulse once per second |
| lock_set | input | 1 | Pulse: lock the keypad |
| lock_int_clr | input | 1 | Pulse: clear the keylock interrupt status |
| u1_code | input | 8 | First unlock code (bit 7 = 1) |
| u2_code | input | 8 | Second unlock code (bit 7 = 1) |
| tmr_cfg | input | 8 | [4:0] wake timer in seconds, [7:5] unlock window in seconds |
| lk_irq_mask | input | 1 | 1 lets the keylock status drive `lock_irq` |
| gpi_lock_cfg | input | 1 | 1 drops general-purpose input events while locked |
| ev_valid | input | 1 | Incoming event valid |
| ev_ready | output | 1 | Incoming event ready |
| ev_data | input | 8 | Event code: bit 7 press, bits 6:0 key |
| rec_valid | output | 1 | Event offered to the FIFO |
| rec_ready | input | 1 | FIFO can take an event |
| rec_data | output | 8 | Event code to the FIFO |
| ke_int_req | output | 1 | One-cycle wake key-event interrupt request |
| lock_int_stat | output | 1 | Sticky keylock interrupt status |
| lock_irq | output | 1 | Keylock interrupt after the mask |
| lck_stat | output | 2 | Lock status, encoded as in R12 |
| gpi_gate | output | 1 | General-purpose input events are being blocked |

## Verification
The bench tests a wrong key pressed between the two codes. A design that kept the first match would unlock on the next press of the second code. It counts ticks one at a time, so that a wake or window timer that expires one tick early or late, or that ignores a zero setting, shows up in `ke_int_req` or `lck_stat`. It also fires a tick together with an accepted event and checks that the window has not expired yet, which shows whether that tick was wrongly counted. Finally, it runs general-purpose input codes both as pass-through events and as unlock codes, so a faulty code-range check either leaks them while they should be blocked or loses them while they should pass.

// File: rtl/kl_pkg.sv
package kl_pkg;
  typedef enum logic [1:0] {
    KL_OPEN  = 2'd0,
    KL_SEEK1 = 2'd1,
    KL_SEEK2 = 2'd2
  } kl_state_e;
endpackage

// File: rtl/kl_timer.sv
// Down-counter clocked by a slow step input. A count of zero means idle,
// so loading zero leaves the timer idle and it never expires.
module kl_timer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         clear,
  input  logic         step,
  input  logic [W-1:0] load_val,
  output logic         expire
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (clear)              cnt <= '0;
    else if (step && cnt != '0)  cnt <= cnt - ONE;
  end

  assign expire = step && !load && !clear && (cnt == ONE);
endmodule

// File: rtl/kl_classify.sv
// Decodes one event code: press flag, input-event range, unlock code hits.
module kl_classify #(
  parameter int CODE_W    = 8,
  parameter int GPI_FIRST = 97,
  parameter int GPI_LAST  = 114
) (
  input  logic [CODE_W-1:0] ev_data,
  input  logic [CODE_W-1:0] u1_code,
  input  logic [CODE_W-1:0] u2_code,
  output logic              is_press,
  output logic              is_gpi,
  output logic [1:0]        hit
);
  localparam int KEY_W = CODE_W - 1;

  logic [CODE_W-1:0] codes [2];
  logic [KEY_W-1:0]  key;

  assign codes[0] = u1_code;
  assign codes[1] = u2_code;
  assign key      = ev_data[KEY_W-1:0];
  assign is_press = ev_data[CODE_W-1];
  assign is_gpi   = (key >= KEY_W'(GPI_FIRST)) && (key <= KEY_W'(GPI_LAST));

  for (genvar g = 0; g < 2; g++) begin : g_hit
    assign hit[g] = is_press && (ev_data == codes[g]);
  end
endmodule

// File: rtl/kl_ctrl.sv
// Lock state machine: wake request, two-step matching, timer control.
module kl_ctrl
  import kl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lock_set,
  input  logic      lock_int_clr,
  input  logic      press,
  input  logic [1:0] hit,
  input  logic      mask_nz,
  input  logic      mask_exp,
  input  logic      win_exp,
  output kl_state_e st,
  output logic      ke_int_req,
  output logic      lock_int_stat,
  output logic      mask_load,
  output logic      mask_clr,
  output logic      win_load,
  output logic      win_clr
);
  kl_state_e st_n;
  logic      woken, woken_n, ke_n, unlock;

  always_comb begin
    st_n      = st;
    woken_n   = woken;
    ke_n      = 1'b0;
    unlock    = 1'b0;
    mask_load = 1'b0;
    mask_clr  = 1'b0;
    win_load  = 1'b0;
    win_clr   = 1'b0;
    if (st == KL_OPEN) begin
      if (lock_set) begin
        st_n     = KL_SEEK1;
        woken_n  = 1'b0;
        mask_clr = 1'b1;
        win_clr  = 1'b1;
      end
    end else if (press) begin
      if (mask_nz && !woken) begin
        ke_n      = 1'b1;
        woken_n   = 1'b1;
        mask_load = 1'b1;
      end
      if (st == KL_SEEK2 && hit[1]) begin
        st_n      = KL_OPEN;
        unlock    = 1'b1;
        ke_n      = 1'b0;
        woken_n   = 1'b0;
        mask_load = 1'b0;
        mask_clr  = 1'b1;
        win_clr   = 1'b1;
      end else if (hit[0]) begin
        st_n     = KL_SEEK2;
        win_load = 1'b1;
      end else begin
        st_n    = KL_SEEK1;
        win_clr = 1'b1;
      end
    end else if (mask_exp) begin
      st_n    = KL_SEEK1;
      woken_n = 1'b0;
      win_clr = 1'b1;
    end else if (win_exp && st == KL_SEEK2) begin
      st_n = KL_SEEK1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= KL_OPEN;
      woken         <= 1'b0;
      ke_int_req    <= 1'b0;
      lock_int_stat <= 1'b0;
    end else begin
      st         <= st_n;
      woken      <= woken_n;
      ke_int_req <= ke_n;
      if (unlock)            lock_int_stat <= 1'b1;
      else if (lock_int_clr) lock_int_stat <= 1'b0;
    end
  end
endmodule

// File: rtl/keylock_seq.sv
module keylock_seq
  import kl_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int MASK_W    = 5,
  parameter int WIN_W     = 3,
  parameter int GPI_FIRST = 97,
  parameter int GPI_LAST  = 114
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic                    lock_set,
  input  logic                    lock_int_clr,
  input  logic [CODE_W-1:0]       u1_code,
  input  logic [CODE_W-1:0]       u2_code,
  input  logic [MASK_W+WIN_W-1:0] tmr_cfg,
  input  logic                    lk_irq_mask,
  input  logic                    gpi_lock_cfg,
  input  logic                    ev_valid,
  output logic                    ev_ready,
  input  logic [CODE_W-1:0]       ev_data,
  output logic                    rec_valid,
  input  logic                    rec_ready,
  output logic [CODE_W-1:0]       rec_data,
  output logic                    ke_int_req,
  output logic                    lock_int_stat,
  output logic                    lock_irq,
  output logic [1:0]              lck_stat,
  output logic                    gpi_gate
);
  localparam int CFG_W = MASK_W + WIN_W;

  logic [MASK_W-1:0] mask_val;
  logic [WIN_W-1:0]  win_val;
  logic              is_press, is_gpi, locked, pass, acc, step;
  logic [1:0]        hit;
  logic              mask_load, mask_clr, win_load, win_clr, mask_exp, win_exp;
  kl_state_e         st;

  assign mask_val = tmr_cfg[MASK_W-1:0];
  assign win_val  = tmr_cfg[CFG_W-1:MASK_W];

  kl_classify #(.CODE_W(CODE_W), .GPI_FIRST(GPI_FIRST), .GPI_LAST(GPI_LAST)) u_cls (
    .ev_data (ev_data),
    .u1_code (u1_code),
    .u2_code (u2_code),
    .is_press(is_press),
    .is_gpi  (is_gpi),
    .hit     (hit)
  );

  assign locked    = (st != KL_OPEN);
  assign pass      = !locked || (is_gpi && !gpi_lock_cfg);
  assign ev_ready  = pass ? rec_ready : 1'b1;
  assign rec_valid = ev_valid && pass;
  assign rec_data  = ev_data;
  assign acc       = ev_valid && ev_ready;
  assign step      = tick && !acc;

  kl_timer #(.W(MASK_W)) u_mask_tmr (
    .clk(clk), .rst_n(rst_n), .load(mask_load), .clear(mask_clr),
    .step(step), .load_val(mask_val), .expire(mask_exp)
  );

  kl_timer #(.W(WIN_W)) u_win_tmr (
    .clk(clk), .rst_n(rst_n), .load(win_load), .clear(win_clr),
    .step(step), .load_val(win_val), .expire(win_exp)
  );

  kl_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .lock_set     (lock_set),
    .lock_int_clr (lock_int_clr),
    .press        (acc && is_press),
    .hit          (hit),
    .mask_nz      (mask_val != '0),
    .mask_exp     (mask_exp),
    .win_exp      (win_exp),
    .st           (st),
    .ke_int_req   (ke_int_req),
    .lock_int_stat(lock_int_stat),
    .mask_load    (mask_load),
    .mask_clr     (mask_clr),
    .win_load     (win_load),
    .win_clr      (win_clr)
  );

  assign lock_irq = lock_int_stat && lk_irq_mask;
  assign lck_stat = {locked, st == KL_SEEK1};
  assign gpi_gate = locked && gpi_lock_cfg;
endmodule

// File: rtl/keylock_seq_chk.sv
module keylock_seq_chk #(
  parameter int CODE_W    = 8,
  parameter int MASK_W    = 5,
  parameter int WIN_W     = 3,
  parameter int GPI_FIRST = 97,
  parameter int GPI_LAST  = 114
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [MASK_W+WIN_W-1:0] tmr_cfg,
  input logic                    lk_irq_mask,
  input logic                    ev_valid,
  input logic                    ev_ready,
  input logic [CODE_W-1:0]       ev_data,
  input logic                    rec_valid,
  input logic                    rec_ready,
  input logic                    ke_int_req,
  input logic                    lock_int_stat,
  input logic                    lock_irq,
  input logic [1:0]              lck_stat,
  input logic                    gpi_gate
);
  localparam int CFG_W = MASK_W + WIN_W;
  localparam logic [CFG_W-1:0] MASK_BITS = CFG_W'((1 << MASK_W) - 1);

  logic gpi_code, wake_off;
  assign gpi_code = (ev_data[CODE_W-2:0] >= (CODE_W-1)'(GPI_FIRST)) &&
                    (ev_data[CODE_W-2:0] <= (CODE_W-1)'(GPI_LAST));
  assign wake_off = (tmr_cfg & MASK_BITS) == '0;

  p_open_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lck_stat == 2'b00) |-> (rec_valid == ev_valid && ev_ready == rec_ready));
  p_locked_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lck_stat[1] && !gpi_code) |-> (!rec_valid && ev_ready));
  p_ke_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ke_int_req |=> !ke_int_req);
  p_no_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready && ev_data[CODE_W-1] && wake_off) |=> !ke_int_req);
  p_unlock_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_int_stat) |-> (lck_stat == 2'b00));
  p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_irq_mask |-> !lock_irq);
  p_gate_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    gpi_gate |-> lck_stat[1]);
  p_stat_code_r12: assert property (@(posedge clk) disable iff (!rst_n)
    lck_stat != 2'b01);
endmodule

bind keylock_seq keylock_seq_chk #(
  .CODE_W(CODE_W), .MASK_W(MASK_W), .WIN_W(WIN_W),
  .GPI_FIRST(GPI_FIRST), .GPI_LAST(GPI_LAST)
) u_chk (.*);

// File: tb/sim_keylock_seq.sv
module sim_keylock_seq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, lock_set = 1'b0, lock_int_clr = 1'b0;
  logic [7:0] u1_code = 8'h8C, u2_code = 8'hAD, tmr_cfg = 8'h43;
  logic       lk_irq_mask = 1'b1, gpi_lock_cfg = 1'b1;
  logic       ev_valid = 1'b0, rec_ready = 1'b1;
  logic [7:0] ev_data = 8'h00;
  logic       ev_ready, rec_valid, ke_int_req, lock_int_stat, lock_irq, gpi_gate;
  logic [7:0] rec_data;
  logic [1:0] lck_stat;
  int total = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keylock_seq u0 (.*);

  localparam logic [8:0] PASS_VEC [6] = '{
    {8'h85, 1'b1}, {8'h05, 1'b0}, {8'hE1, 1'b1},
    {8'h50, 1'b0}, {8'hF2, 1'b1}, {8'h8C, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] c);
    @(negedge clk); ev_valid = 1'b1; ev_data = c;
    @(negedge clk); ev_valid = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic do_lock();
    @(negedge clk); lock_set = 1'b1;
    @(negedge clk); lock_set = 1'b0;
  endtask

  task automatic do_clr();
    @(negedge clk); lock_int_clr = 1'b1;
    @(negedge clk); lock_int_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 lck_stat in reset", lck_stat, 2'b00);
    chk("R1 stat in reset", {lock_int_stat, lock_irq, ke_int_req, gpi_gate}, 4'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 lck_stat after reset", lck_stat, 2'b00);

    // R2: pass-through vectors while unlocked
    foreach (PASS_VEC[i]) begin
      @(negedge clk);
      ev_valid = 1'b1; ev_data = PASS_VEC[i][8:1]; rec_ready = PASS_VEC[i][0];
      #1;
      chk("R2 rec_valid", rec_valid, 1'b1);
      chk("R2 rec_data", rec_data, PASS_VEC[i][8:1]);
      chk("R2 ev_ready", ev_ready, PASS_VEC[i][0]);
    end
    @(negedge clk); ev_valid = 1'b0; rec_ready = 1'b1;

    // lock, wake once
    do_lock();
    chk("R12 locked idle", lck_stat, 2'b11);
    chk("R11 gate on", gpi_gate, 1'b1);
    @(negedge clk); rec_ready = 1'b0; ev_valid = 1'b1; ev_data = 8'h85; #1;
    chk("R3 rec_valid dropped", rec_valid, 1'b0);
    chk("R3 ev_ready high", ev_ready, 1'b1);
    @(negedge clk); ev_valid = 1'b0; rec_ready = 1'b1;
    chk("R4 wake pulse", ke_int_req, 1'b1);
    @(negedge clk);
    chk("R4 pulse one cycle", ke_int_req, 1'b0);
    send(8'h86);
    chk("R4 no second wake", ke_int_req, 1'b0);

    // unlock sequence
    send(8'h8C);
    chk("R12 first code seen", lck_stat, 2'b10);
    do_lock();
    chk("R14 relock ignored", lck_stat, 2'b10);
    send(8'h0C);
    chk("R10 release ignored", lck_stat, 2'b10);
    send(8'hAD);
    chk("R7 unlocked", lck_stat, 2'b00);
    chk("R7 status set", lock_int_stat, 1'b1);
    chk("R8 irq with mask", lock_irq, 1'b1);
    do_clr();
    chk("R8 cleared", {lock_int_stat, lock_irq}, 2'b00);

    lk_irq_mask = 1'b0;
    do_lock(); send(8'h8C); send(8'hAD);
    chk("R8 status set masked", lock_int_stat, 1'b1);
    chk("R8 irq masked", lock_irq, 1'b0);
    do_clr(); lk_irq_mask = 1'b1;

    // wrong key between codes
    do_lock(); send(8'h8C);
    chk("R4 wake on first code", lck_stat, 2'b10);
    send(8'h81);
    chk("R10 wrong key restarts", lck_stat, 2'b11);
    send(8'hAD);
    chk("R10 second code alone", lck_stat, 2'b11);

    // wake timer expiry (3 ticks)
    do_tick(); do_tick(); send(8'h85);
    chk("R5 no wake before expiry", ke_int_req, 1'b0);
    do_tick(); send(8'h85);
    chk("R5 wake after expiry", ke_int_req, 1'b1);

    // window expiry (2 ticks)
    send(8'h8C);
    chk("R9 window start", lck_stat, 2'b10);
    do_tick();
    chk("R9 window one tick", lck_stat, 2'b10);
    do_tick();
    chk("R9 window expired", lck_stat, 2'b11);
    send(8'hAD);
    chk("R9 late second code", lck_stat, 2'b11);
    do_tick();

    // tick alongside accepted event is not counted
    send(8'h8C);
    chk("R4 wake after restart", ke_int_req, 1'b1);
    do_tick();
    @(negedge clk); tick = 1'b1; ev_valid = 1'b1; ev_data = 8'h05;
    @(negedge clk); tick = 1'b0; ev_valid = 1'b0;
    chk("R13 tick with event skipped", lck_stat, 2'b10);
    do_tick();
    chk("R13 next tick expires", lck_stat, 2'b11);

    // wake disabled, unlimited window
    do_tick();
    tmr_cfg = 8'h00;
    send(8'h85);
    chk("R6 no wake when zero", ke_int_req, 1'b0);
    send(8'h8C);
    for (int k = 0; k < 10; k++) do_tick();
    chk("R9 zero window unlimited", lck_stat, 2'b10);
    send(8'hAD);
    chk("R7 unlock after wait", lck_stat, 2'b00);
    do_clr();

    // input events while locked
    gpi_lock_cfg = 1'b0;
    do_lock();
    chk("R11 gate off", gpi_gate, 1'b0);
    @(negedge clk); ev_valid = 1'b1; ev_data = 8'hE1; #1;
    chk("R11 input event passes", rec_valid, 1'b1);
    @(negedge clk); ev_data = 8'h85; #1;
    chk("R3 key dropped", rec_valid, 1'b0);
    @(negedge clk); ev_valid = 1'b0; gpi_lock_cfg = 1'b1; #1;
    chk("R11 gate on again", gpi_gate, 1'b1);
    ev_valid = 1'b1; ev_data = 8'hE1; #1;
    chk("R11 input event blocked", rec_valid, 1'b0);
    @(negedge clk); ev_valid = 1'b0;
    u1_code = 8'hE1; u2_code = 8'hF2;
    send(8'hE1);
    chk("R11 input code as first", lck_stat, 2'b10);
    send(8'hF2);
    chk("R11 input code unlocks", lck_stat, 2'b00);
    chk("R7 status via input codes", lock_int_stat, 1'b1);

    // reset while locked
    do_lock();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears lock", lck_stat, 2'b00);
    chk("R1 reset clears status", lock_int_stat, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule